// File: doc/BRIEF.md
# Monochrome Page Upscaler Streamer

This block turns one page of a 128x64 monochrome frame into a stream of 16-bit colour writes for a 320x240 panel at twice the size in both directions. A page covers 128 columns and 8 pixel rows. The page buffer stores each column as one byte, and bit j of that byte is pixel row j of the page. The block reads the buffer through an address/data port with asynchronous read. It walks the columns once for every row bit and every repeat of a line, and it sends each pixel twice. The vertical byte columns therefore leave the block as a horizontal raster, and no line store is kept.

A page starts with a one-cycle `start` pulse. When `first` is high at that pulse, the block sends the window-setup sequence before any pixel. That sequence opens a 256x128 window centred on the panel and then begins a memory write. Each item on the output stream is flagged as a command or as data, and an item moves only in a cycle where valid and ready are both high. When the last pixel of the page has been accepted, `done` pulses for one cycle.

Control is a four-state machine:
- IDLE waits. On `start` it goes to WINDOW if `first` is high, otherwise to PIXELS.
- WINDOW sends the eleven setup items. After the last one is accepted it goes to PIXELS.
- PIXELS sends 4096 pixels. After the last one is accepted it goes to FINISH.
- FINISH raises `done` for one cycle and then returns to IDLE.

Top module: `mono_page_upscaler`

## Requirements
- R1: After reset, `out_valid`, `busy` and `done` are all low.
- R2: A `start` with `first`=1 first emits exactly eleven items, with `out_is_cmd`=1 marking a command and 0 marking data. The items are: command 0x2A, four data bytes, command 0x2B, four data bytes, command 0x2C.
- R3: Each of the four coordinates in the window sequence is sent as two data bytes in `out_data[7:0]`, high byte first, with the upper bits zero. The values are X start 32, X end 287, Y start 56 and Y end 183.
- R4: Every pixel is a data item (`out_is_cmd`=0). A set bit gives 0x7FFF and a clear bit gives 0x0000.
- R5: A page is exactly 4096 pixels. For each bit index j from 0 to 7, the 256-pixel line is built by sending each column from 0 to 127 twice in a row. That line is sent two times back to back before j increases.
- R6: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_is_cmd` stay unchanged, and nothing is skipped or repeated.
- R7: `done` is high for exactly one cycle, in the cycle right after the last pixel is accepted. `out_valid` is low in that cycle, and `busy` is low in the cycle after it.
- R8: A `start` with `first`=0 emits no window items: the first item is pixel 0 of the page.
- R9: A `start` pulse while `busy` is high has no effect. No extra item is emitted and no second page follows.
- R10: While a pixel is presented, `rd_addr` equals the column that pixel comes from.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to stream a page |
| first | input | 1 | Sampled with `start`: send the window setup first |
| rd_addr | output | 7 | Page-buffer column address |
| rd_data | input | 8 | Column byte at `rd_addr`, same cycle |
| out_valid | output | 1 | Output item valid |
| out_ready | input | 1 | Sink accepts the item |
| out_is_cmd | output | 1 | 1 = command byte, 0 = data |
| out_data | output | 16 | Command/coordinate byte (zero-extended) or pixel |
| busy | output | 1 | Page in progress |
| done | output | 1 | One-cycle page-complete pulse |

## Verification
The stall-stability property assumes two things. The page buffer returns the byte for `rd_addr` in the same cycle. Its contents stay fixed while a page streams, so a stalled pixel cannot change its value. The bench models the buffer as a combinational array that it writes only between pages. It drives `start` only as a single-cycle pulse, and it varies `out_ready` through several periodic patterns, so both back-pressure and full-rate transfer occur.

// File: rtl/upsc_pkg.sv
package upsc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WINDOW,
        ST_PIXELS,
        ST_FINISH
    } upsc_state_t;

    localparam logic [7:0] CMD_COL_RANGE = 8'h2A;
    localparam logic [7:0] CMD_ROW_RANGE = 8'h2B;
    localparam logic [7:0] CMD_MEM_WRITE = 8'h2C;
    localparam int unsigned WIN_ITEMS     = 11;

endpackage

// File: rtl/upsc_window_seq.sv
module upsc_window_seq
    import upsc_pkg::*;
#(
    parameter int unsigned X_ORIGIN = 32,
    parameter int unsigned Y_ORIGIN = 56,
    parameter int unsigned WIN_W    = 256,
    parameter int unsigned WIN_H    = 128
) (
    input  logic [3:0] idx,
    output logic       is_cmd,
    output logic [7:0] value,
    output logic       last
);
    localparam logic [15:0] XS = 16'(X_ORIGIN);
    localparam logic [15:0] XE = 16'(X_ORIGIN + WIN_W - 1);
    localparam logic [15:0] YS = 16'(Y_ORIGIN);
    localparam logic [15:0] YE = 16'(Y_ORIGIN + WIN_H - 1);

    always_comb begin
        is_cmd = 1'b0;
        value  = 8'h00;
        unique case (idx)
            4'd0:    begin is_cmd = 1'b1; value = CMD_COL_RANGE; end
            4'd1:    value = XS[15:8];
            4'd2:    value = XS[7:0];
            4'd3:    value = XE[15:8];
            4'd4:    value = XE[7:0];
            4'd5:    begin is_cmd = 1'b1; value = CMD_ROW_RANGE; end
            4'd6:    value = YS[15:8];
            4'd7:    value = YS[7:0];
            4'd8:    value = YE[15:8];
            4'd9:    value = YE[7:0];
            4'd10:   begin is_cmd = 1'b1; value = CMD_MEM_WRITE; end
            default: begin is_cmd = 1'b0; value = 8'h00; end
        endcase
    end

    assign last = (idx == 4'(WIN_ITEMS - 1));

endmodule

// File: rtl/upsc_raster_walker.sv
module upsc_raster_walker #(
    parameter int unsigned COLS      = 128,
    parameter int unsigned PAGE_ROWS = 8,
    localparam int unsigned COL_W    = $clog2(COLS),
    localparam int unsigned ROW_W    = $clog2(PAGE_ROWS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             step,
    output logic [COL_W-1:0] col,
    output logic [ROW_W-1:0] row_bit,
    output logic             last
);
    logic dup_q;
    logic pass_q;
    logic col_wrap;
    logic row_wrap;

    assign col_wrap = (col == COL_W'(COLS - 1));
    assign row_wrap = (row_bit == ROW_W'(PAGE_ROWS - 1));
    assign last     = dup_q && col_wrap && pass_q && row_wrap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dup_q   <= 1'b0;
            col     <= '0;
            pass_q  <= 1'b0;
            row_bit <= '0;
        end else if (clear) begin
            dup_q   <= 1'b0;
            col     <= '0;
            pass_q  <= 1'b0;
            row_bit <= '0;
        end else if (step) begin
            dup_q <= ~dup_q;
            if (dup_q) begin
                col <= col_wrap ? '0 : col + 1'b1;
                if (col_wrap) begin
                    pass_q <= ~pass_q;
                    if (pass_q) begin
                        row_bit <= row_wrap ? '0 : row_bit + 1'b1;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/mono_page_upscaler.sv
module mono_page_upscaler
    import upsc_pkg::*;
#(
    parameter int unsigned COLS       = 128,
    parameter int unsigned PAGE_ROWS  = 8,
    parameter int unsigned FRAME_ROWS = 64,
    parameter int unsigned X_ORIGIN   = 32,
    parameter int unsigned Y_ORIGIN   = 56,
    parameter int unsigned PIX_W      = 16,
    parameter logic [15:0] ON_COLOR   = 16'h7FFF,
    parameter logic [15:0] OFF_COLOR  = 16'h0000,
    localparam int unsigned COL_W     = $clog2(COLS),
    localparam int unsigned ROW_W     = $clog2(PAGE_ROWS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic                 first,
    output logic [COL_W-1:0]     rd_addr,
    input  logic [PAGE_ROWS-1:0] rd_data,
    output logic                 out_valid,
    input  logic                 out_ready,
    output logic                 out_is_cmd,
    output logic [PIX_W-1:0]     out_data,
    output logic                 busy,
    output logic                 done
);
    upsc_state_t state, state_nx;

    logic             fire;
    logic [3:0]       win_idx;
    logic             win_is_cmd;
    logic [7:0]       win_value;
    logic             win_last;
    logic [COL_W-1:0] col;
    logic [ROW_W-1:0] row_bit;
    logic             page_last;

    upsc_window_seq #(
        .X_ORIGIN (X_ORIGIN),
        .Y_ORIGIN (Y_ORIGIN),
        .WIN_W    (2 * COLS),
        .WIN_H    (2 * FRAME_ROWS)
    ) u_win (
        .idx    (win_idx),
        .is_cmd (win_is_cmd),
        .value  (win_value),
        .last   (win_last)
    );

    upsc_raster_walker #(
        .COLS      (COLS),
        .PAGE_ROWS (PAGE_ROWS)
    ) u_walk (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (state == ST_IDLE),
        .step    (fire && (state == ST_PIXELS)),
        .col     (col),
        .row_bit (row_bit),
        .last    (page_last)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Setup-sequence index
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                             win_idx <= '0;
        else if (state == ST_IDLE)              win_idx <= '0;
        else if (fire && state == ST_WINDOW)    win_idx <= win_idx + 1'b1;
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (start) state_nx = first ? ST_WINDOW : ST_PIXELS;
            ST_WINDOW: if (fire && win_last) state_nx = ST_PIXELS;
            ST_PIXELS: if (fire && page_last) state_nx = ST_FINISH;
            ST_FINISH: state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    assign fire = out_valid && out_ready;

    // Output logic
    always_comb begin
        out_valid  = 1'b0;
        out_is_cmd = 1'b0;
        out_data   = '0;
        busy       = 1'b1;
        done       = 1'b0;
        unique case (state)
            ST_IDLE: busy = 1'b0;
            ST_WINDOW: begin
                out_valid  = 1'b1;
                out_is_cmd = win_is_cmd;
                out_data   = PIX_W'(win_value);
            end
            ST_PIXELS: begin
                out_valid = 1'b1;
                out_data  = rd_data[row_bit] ? PIX_W'(ON_COLOR) : PIX_W'(OFF_COLOR);
            end
            ST_FINISH: done = 1'b1;
            default:   busy = 1'b0;
        endcase
    end

    assign rd_addr = col;

endmodule

// File: rtl/upsc_checker.sv
module upsc_checker #(
    parameter int unsigned COL_W    = 7,
    parameter int unsigned PIX_W    = 16,
    parameter logic [15:0] ON_COLOR = 16'h7FFF
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic [COL_W-1:0] rd_addr,
    input logic             out_valid,
    input logic             out_ready,
    input logic             out_is_cmd,
    input logic [PIX_W-1:0] out_data,
    input logic             busy,
    input logic             done
);
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !out_valid && !done);

    a_r6_hold_item: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_is_cmd));

    a_r10_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready && !out_is_cmd |=> $stable(rd_addr));

    a_r4_pixel_codes: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_is_cmd |-> out_data == PIX_W'(ON_COLOR) || out_data[PIX_W-1:8] == '0);

    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done && !busy);

    a_r7_done_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !out_valid && busy);

    a_r9_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && start |=> busy);

endmodule

bind mono_page_upscaler upsc_checker #(
    .COL_W    (COL_W),
    .PIX_W    (PIX_W),
    .ON_COLOR (ON_COLOR)
) u_upsc_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .rd_addr    (rd_addr),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_is_cmd (out_is_cmd),
    .out_data   (out_data),
    .busy       (busy),
    .done       (done)
);

// File: tb/tb_mono_page_upscaler.sv
module tb_mono_page_upscaler;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        first = 1'b0;
    logic [6:0]  rd_addr;
    logic [7:0]  rd_data;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic        out_is_cmd;
    logic [15:0] out_data;
    logic        busy;
    logic        done;

    logic [7:0] page [128];
    int checks = 0;
    int failures = 0;
    bit timed_out = 1'b0;

    always #4 clk = ~clk;

    assign rd_data = page[rd_addr];

    mono_page_upscaler dut (
        .clk(clk), .rst_n(rst_n), .start(start), .first(first),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_is_cmd(out_is_cmd), .out_data(out_data),
        .busy(busy), .done(done)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Window items: {is_cmd, byte}
    function automatic logic [16:0] win_exp(input int k);
        case (k)
            0: return {1'b1, 16'h002A};
            1: return {1'b0, 16'h0000};
            2: return {1'b0, 16'h0020};
            3: return {1'b0, 16'h0001};
            4: return {1'b0, 16'h001F};
            5: return {1'b1, 16'h002B};
            6: return {1'b0, 16'h0000};
            7: return {1'b0, 16'h0038};
            8: return {1'b0, 16'h0000};
            9: return {1'b0, 16'h00B7};
            default: return {1'b1, 16'h002C};
        endcase
    endfunction

    function automatic bit ready_at(input int mode, input int cyc);
        case (mode)
            0: return 1'b1;
            1: return (cyc % 3) != 0;
            default: return (cyc % 5) < 2;
        endcase
    endfunction

    // Stream one page and check every item; poke = transfer index at which to pulse start
    task automatic run_page(input bit with_win, input int mode, input int poke);
        int n_win = with_win ? 11 : 0;
        int total = n_win + 4096;
        int got = 0;
        int cyc = 0;
        bit stalled = 1'b0;
        logic [16:0] held = '0;
        @(negedge clk);
        first = with_win; start = 1'b1;
        @(negedge clk);
        start = 1'b0; first = 1'b0;
        while (got < total && !timed_out) begin
            out_ready = ready_at(mode, cyc);
            start = (poke >= 0 && got == poke) ? 1'b1 : 1'b0;
            #1;
            if (stalled) check("R6 stall hold", {15'd0, out_valid, out_is_cmd, out_data}, {15'd0, 1'b1, held});
            check("R7 done low mid-page", {31'd0, done}, 32'd0);
            if (out_valid && out_ready) begin
                if (got < n_win) begin
                    check(got == 0 ? "R2 window cmd" : "R3 window coord",
                          {15'd0, out_is_cmd, out_data}, {15'd0, win_exp(got)});
                end else begin
                    int p = got - n_win;
                    int j = p / 512;
                    int c = (p % 256) / 2;
                    logic [15:0 ] e = page[c][j] ? 16'h7FFF : 16'h0000;
                    if (p == 0 && !with_win)
                        check("R8 first item is pixel", {15'd0, out_is_cmd, out_data}, {15'd0, 1'b0, e});
                    else
                        check("R4 R5 pixel", {15'd0, out_is_cmd, out_data}, {15'd0, 1'b0, e});
                    check("R10 rd_addr", {25'd0, rd_addr}, c);
                end
                got++;
                stalled = 1'b0;
            end else begin
                stalled = out_valid;
                held = {out_is_cmd, out_data};
            end
            cyc++;
            @(negedge clk);
        end
        start = 1'b0;
        out_ready = 1'b1;
        #1;
        check("R7 done pulse", {30'd0, done, out_valid}, {30'd0, 2'b10});
        @(negedge clk); #1;
        check("R7 done one cycle", {30'd0, done, busy}, 32'd0);
        check("R5 page count", got, total);
    endtask

    task automatic t_reset();
        #1;
        check("R1 reset", {29'd0, out_valid, busy, done}, 32'd0);
    endtask

    task automatic t_page_window_fullrate();
        for (int c = 0; c < 128; c++) page[c] = 8'((c * 37 + 5) ^ (c >> 2));
        run_page(1'b1, 0, -1);
    endtask

    task automatic t_page_plain_stalled();
        for (int c = 0; c < 128; c++) page[c] = (c == 0) ? 8'hFF : (c == 127) ? 8'h00 : ((c % 2) ? 8'hA5 : 8'h3C);
        run_page(1'b0, 1, -1);
    endtask

    task automatic t_start_while_busy();
        for (int c = 0; c < 128; c++) page[c] = 8'(c);
        run_page(1'b1, 2, 2000);
        for (int i = 0; i < 20; i++) begin
            @(negedge clk); #1;
            check("R9 no second page", {30'd0, out_valid, busy}, 32'd0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        timed_out = 1'b1;
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int c = 0; c < 128; c++) page[c] = 8'h00;
        t_reset();
        repeat (2) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_page_window_fullrate();
        t_page_plain_stalled();
        t_start_while_busy();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule